// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a memory-mapped timer peripheral built around one down counter. Software reaches it through a word-indexed register port with a write strobe, write data and a combinational read path. The counter advances on prescaled pulses of a timer clock-enable input. When the count runs out, the block raises an interrupt flag. A control register sets how the counter behaves. It can count in 16 or 32 bits. It can reload either to the full counter range or to a programmed value. It can either wrap or stop at zero. The prescaler divides by 1, 16 or 256, and an enable bit masks the interrupt.

There are two ways to write the reload value. The immediate load register also restarts the count at once. The background load register only changes the value taken at the next natural reload. Software sees the interrupt flag both raw and masked, and clears it by writing to a dedicated register. The block drives one interrupt output, which is the masked flag.

Top module: `interval_timer`

## Requirements
- R1: After reset the control register reads 0x20 (interrupt enable only: stopped, free-running, 16-bit, divide by 1), the load register reads 0, the value register reads 0xFFFF, both status registers read 0 and the interrupt output is low.
- R2: The register at index 2 holds control bits 7:0 exactly as written and reads them back with bits 31:8 zero. The fields are: bit 0 one-shot, bit 1 32-bit size, bits 3:2 prescale, bit 5 interrupt enable, bit 6 periodic, bit 7 run.
- R3: While the run bit is clear, or while the tick-enable input is low, the count does not change.
- R4: The count decrements once every 1, 16 or 256 tick-enable pulses for prescale codes 00, 01 and 10. Code 11 acts as divide by 1. Any write to index 2 that changes the prescale code restarts the divide count from zero.
- R5: A step from 1 to 0 sets the interrupt flag. The next step from 0 reloads the count: to 0xFFFF (16-bit) or 0xFFFFFFFF (32-bit) when the periodic bit is clear, and to the stored load value when it is set.
- R6: With the one-shot bit set, a count of 0 stays at 0 on later steps and sets the flag no more.
- R7: A write to index 0 stores the load value and in the same edge sets the count to the reload value the new data gives. This write takes priority over a step in that cycle, and no flag is set.
- R8: A write to index 6 stores the load value without touching the count. Indices 0 and 6 both read the stored load value.
- R9: Writes to indices 1, 4, 5 and 7 change no state.
- R10: Any write to index 3 clears the flag. If a 1-to-0 step happens in the same cycle, the flag is set instead.
- R11: Index 4 bit 0 reads the flag. Index 5 bit 0 and the interrupt output both equal the flag ANDed with control bit 5.
- R12: In 16-bit mode only the low 16 bits of the count are used, reloads are truncated to 16 bits, and index 1 reads with bits 31:16 zero.
- R13: Indices 3 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer clock enable, one pulse per raw tick |
| addr | input | 3 | Register word index |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Masked interrupt |

## Verification
Two situations are hard to reach. The first is a free-running wrap. Counting down from 0xFFFF or 0xFFFFFFFF would take far too long, so the stimulus loads a small periodic value and then clears the periodic bit while the count is still small. The count then reaches zero and wraps to the full range within a few ticks. The second is a clear write that lands in the same cycle as a 1-to-0 step. The stimulus gets there by loading the count with 1 while ticks are held off, and then issuing the clear together with the first tick.

// File: rtl/interval_timer.sv
module interval_timer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic [2:0]  addr,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        irq
);

  localparam logic [2:0] A_LOAD = 3'd0;
  localparam logic [2:0] A_VAL  = 3'd1;
  localparam logic [2:0] A_CTRL = 3'd2;
  localparam logic [2:0] A_CLR  = 3'd3;
  localparam logic [2:0] A_RAW  = 3'd4;
  localparam logic [2:0] A_MSK  = 3'd5;
  localparam logic [2:0] A_BG   = 3'd6;
  localparam logic [7:0] CTRL_RST = 8'h20;

  logic [7:0]  ctrl;
  logic [31:0] load_q;
  logic [31:0] count_q;
  logic [7:0]  pre_q;
  logic        flag_q;
  logic [7:0]  pre_last;

  wire run      = ctrl[7];
  wire one_shot = ctrl[0];
  wire wide     = ctrl[1];
  wire ie       = ctrl[5];
  wire periodic = ctrl[6];
  wire [1:0] psel = ctrl[3:2];

  wire wr_load = wr_en && (addr == A_LOAD);
  wire wr_ctrl = wr_en && (addr == A_CTRL);
  wire wr_clr  = wr_en && (addr == A_CLR);
  wire wr_bg   = wr_en && (addr == A_BG);

  always_comb begin
    case (psel)
      2'b01:   pre_last = 8'd15;
      2'b10:   pre_last = 8'd255;
      default: pre_last = 8'd0;
    endcase
  end

  wire pre_hit    = (pre_q == pre_last);
  wire step       = run && tick_en && pre_hit;
  wire presc_chg  = wr_ctrl && (wr_data[3:2] != psel);
  wire [31:0] size_mask = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  wire [31:0] eff       = count_q & size_mask;
  wire [31:0] reload_q  = (periodic ? load_q  : 32'hFFFF_FFFF) & size_mask;
  wire [31:0] reload_wr = (periodic ? wr_data : 32'hFFFF_FFFF) & size_mask;
  wire hit_end    = step && !wr_load && (eff == 32'd1);

  always_ff @(posedge clk) begin
    if (!rst_n)
      pre_q <= 8'd0;
    else if (presc_chg)
      pre_q <= 8'd0;
    else if (run && tick_en)
      pre_q <= pre_hit ? 8'd0 : pre_q + 8'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= CTRL_RST;
      load_q <= 32'd0;
    end else begin
      if (wr_ctrl)
        ctrl <= wr_data[7:0];
      if (wr_load || wr_bg)
        load_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      count_q <= 32'hFFFF_FFFF;
    else if (wr_load)
      count_q <= reload_wr;
    else if (step) begin
      if (eff == 32'd0) begin
        if (!one_shot)
          count_q <= reload_q;
      end else begin
        count_q <= eff - 32'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else if (hit_end)
      flag_q <= 1'b1;
    else if (wr_clr)
      flag_q <= 1'b0;
  end

  always_comb begin
    case (addr)
      A_LOAD, A_BG: rd_data = load_q;
      A_VAL:        rd_data = eff;
      A_CTRL:       rd_data = {24'd0, ctrl};
      A_RAW:        rd_data = {31'd0, flag_q};
      A_MSK:        rd_data = {31'd0, flag_q & ie};
      default:      rd_data = 32'd0;
    endcase
  end

  assign irq = flag_q & ie;

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_load) |=> $stable(count_q)); // R3
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wr_load) |=> $stable(count_q)); // R3
  AST_ONESHOT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (run && one_shot && eff == 32'd0 && !wr_load) |=> $stable(count_q)); // R6
  AST_LOAD_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_load && wide && periodic) |=> (count_q == $past(wr_data))); // R7
  AST_BG_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bg && !run) |=> $stable(count_q)); // R8
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !hit_end) |=> !flag_q); // R10
  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(run && tick_en)); // R5
  AST_NARROW_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && addr == A_VAL) |-> (rd_data[31:16] == 16'd0)); // R12

endmodule

// File: tb/interval_timer_test.sv
module interval_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = 32'd0;
  logic [31:0] rd_data;
  logic        irq;

  always #4 clk = ~clk;

  interval_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";
  logic [31:0] last_rd;
  logic        last_irq;

  logic [7:0]  m_ctrl;
  logic [31:0] m_load, m_count;
  int          m_pre;
  bit          m_flag;

  function automatic logic [31:0] mread(input logic [2:0] a);
    logic [31:0] full = m_ctrl[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    case (a)
      3'd0, 3'd6: return m_load;
      3'd1:       return m_count & full;
      3'd2:       return {24'd0, m_ctrl};
      3'd4:       return {31'd0, m_flag};
      3'd5:       return {31'd0, m_flag & m_ctrl[5]};
      default:    return 32'd0;
    endcase
  endfunction

  function automatic void mstep(input logic [2:0] a, input bit we, input logic [31:0] d, input bit te);
    int div = (m_ctrl[3:2] == 2'b01) ? 16 : (m_ctrl[3:2] == 2'b10) ? 256 : 1;
    bit en = m_ctrl[7];
    bit stp = en && te && (m_pre == div - 1);
    logic [31:0] full = m_ctrl[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    logic [31:0] eff = m_count & full;
    bit per = m_ctrl[6];
    bit set = 0;
    if (we && a == 3'd0)
      m_count = (per ? d : 32'hFFFF_FFFF) & full;
    else if (stp) begin
      if (eff == 0) begin
        if (!m_ctrl[0]) m_count = (per ? m_load : 32'hFFFF_FFFF) & full;
      end else begin
        m_count = eff - 1;
        if (eff == 1) set = 1;
      end
    end
    if (we && a == 3'd2 && d[3:2] != m_ctrl[3:2]) m_pre = 0;
    else if (en && te) m_pre = (m_pre == div - 1) ? 0 : m_pre + 1;
    if (set) m_flag = 1;
    else if (we && a == 3'd3) m_flag = 0;
    if (we && (a == 3'd0 || a == 3'd6)) m_load = d;
    if (we && a == 3'd2) m_ctrl = d[7:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(input logic [2:0] a, input bit we, input logic [31:0] d, input bit te);
    addr = a; wr_en = we; wr_data = d; tick_en = te;
    #1;
    last_rd = rd_data;
    last_irq = irq;
    chk({cur_req, " model rd_data"}, rd_data, mread(a));
    chk({cur_req, " model irq"}, {31'd0, irq}, {31'd0, m_flag & m_ctrl[5]});
    @(posedge clk);
    mstep(a, we, d, te);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cyc(a, 1'b1, d, 1'b0);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) cyc(3'd1, 1'b0, 32'd0, 1'b1);
  endtask

  task automatic rdchk(input string req, input logic [2:0] a, input logic [31:0] exp);
    cyc(a, 1'b0, 32'd0, 1'b0);
    chk(req, last_rd, exp);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    m_ctrl = 8'h20; m_load = 0; m_count = 32'hFFFF_FFFF; m_pre = 0; m_flag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R1";
    rdchk("R1 ctrl", 3'd2, 32'h20);
    rdchk("R1 value", 3'd1, 32'hFFFF);
    rdchk("R1 raw", 3'd4, 32'd0);
    rdchk("R1 masked", 3'd5, 32'd0);
    rdchk("R1 load", 3'd0, 32'd0);
    chk("R1 irq", {31'd0, last_irq}, 32'd0);
    cur_req = "R13";
    rdchk("R13 idx3", 3'd3, 32'd0);
    rdchk("R13 idx7", 3'd7, 32'd0);

    cur_req = "R2";
    wr(3'd2, 32'hFFFF_FF5A);
    rdchk("R2 ctrl readback", 3'd2, 32'h5A);
    wr(3'd2, 32'h20);

    cur_req = "R7";
    wr(3'd0, 32'd5);
    rdchk("R7 free-running load sets full range", 3'd1, 32'hFFFF);
    rdchk("R8 load via idx0", 3'd0, 32'd5);
    rdchk("R8 load via idx6", 3'd6, 32'd5);
    wr(3'd2, 32'hE0);
    wr(3'd0, 32'd3);
    rdchk("R7 periodic load immediate", 3'd1, 32'd3);

    cur_req = "R5";
    tick(3);
    rdchk("R5 flag at end", 3'd4, 32'd1);
    chk("R11 irq set", {31'd0, last_irq}, 32'd1);
    rdchk("R11 masked set", 3'd5, 32'd1);
    tick(1);
    rdchk("R5 periodic reload", 3'd1, 32'd3);

    cur_req = "R10";
    wr(3'd3, 32'hDEAD);
    rdchk("R10 clear", 3'd4, 32'd0);
    wr(3'd0, 32'd1);
    cyc(3'd3, 1'b1, 32'd0, 1'b1);
    rdchk("R10 set wins over clear", 3'd4, 32'd1);

    cur_req = "R11";
    wr(3'd2, 32'hC0);
    rdchk("R11 raw unmasked", 3'd4, 32'd1);
    rdchk("R11 masked off", 3'd5, 32'd0);
    chk("R11 irq masked", {31'd0, last_irq}, 32'd0);
    wr(3'd2, 32'hE0);
    wr(3'd3, 32'd0);

    cur_req = "R9";
    wr(3'd1, 32'h1234);
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rdchk("R9 value unchanged", 3'd1, 32'd0);
    rdchk("R9 load unchanged", 3'd0, 32'd1);
    rdchk("R9 ctrl unchanged", 3'd2, 32'hE0);
    rdchk("R9 flag unchanged", 3'd4, 32'd0);

    cur_req = "R8";
    wr(3'd0, 32'd6);
    wr(3'd6, 32'd2);
    rdchk("R8 bg keeps count", 3'd1, 32'd6);
    rdchk("R8 bg stores load", 3'd0, 32'd2);
    tick(7);
    rdchk("R8 bg used at reload", 3'd1, 32'd2);
    wr(3'd3, 32'd0);

    cur_req = "R3";
    for (int i = 0; i < 60; i++) cyc(3'd1, 1'b0, 32'd0, bit'($urandom_range(1, 0)));
    cyc(3'd1, 1'b0, 32'd0, 1'b0);
    begin
      logic [31:0] v = last_rd;
      for (int i = 0; i < 5; i++) cyc(3'd1, 1'b0, 32'd0, 1'b0);
      rdchk("R3 hold without tick", 3'd1, v);
      wr(3'd2, 32'h60);
      tick(5);
      rdchk("R3 hold while stopped", 3'd1, v);
    end

    cur_req = "R4";
    wr(3'd2, 32'hE4);
    wr(3'd0, 32'd100);
    tick(15);
    rdchk("R4 div16 before 16th", 3'd1, 32'd100);
    tick(1);
    rdchk("R4 div16 step", 3'd1, 32'd99);
    tick(7);
    wr(3'd2, 32'hE8);
    tick(255);
    rdchk("R4 div256 restart", 3'd1, 32'd99);
    tick(1);
    rdchk("R4 div256 step", 3'd1, 32'd98);
    wr(3'd2, 32'hEC);
    tick(1);
    rdchk("R4 code 11 divides by 1", 3'd1, 32'd97);
    wr(3'd2, 32'hE4);
    for (int i = 0; i < 300; i++) cyc(3'd1, 1'b0, 32'd0, bit'($urandom_range(1, 0)));

    cur_req = "R6";
    wr(3'd2, 32'hE1);
    wr(3'd3, 32'd0);
    wr(3'd0, 32'd2);
    tick(2);
    rdchk("R6 one-shot flag", 3'd4, 32'd1);
    wr(3'd3, 32'd0);
    tick(5);
    rdchk("R6 one-shot parked", 3'd1, 32'd0);
    rdchk("R6 no second flag", 3'd4, 32'd0);

    cur_req = "R5";
    wr(3'd2, 32'hE0);
    wr(3'd0, 32'd2);
    wr(3'd2, 32'hA0);
    tick(3);
    rdchk("R5 free-running 16-bit wrap", 3'd1, 32'hFFFF);
    tick(1);
    rdchk("R5 free-running continues", 3'd1, 32'hFFFE);
    wr(3'd2, 32'hE2);
    wr(3'd0, 32'd2);
    wr(3'd2, 32'hA2);
    tick(3);
    rdchk("R5 free-running 32-bit wrap", 3'd1, 32'hFFFF_FFFF);

    cur_req = "R12";
    wr(3'd2, 32'hE2);
    wr(3'd0, 32'h0001_2345);
    wr(3'd2, 32'hE0);
    rdchk("R12 narrow read", 3'd1, 32'h2345);
    tick(1);
    rdchk("R12 narrow decrement", 3'd1, 32'h2344);
    wr(3'd0, 32'h0001_0005);
    rdchk("R12 narrow reload", 3'd1, 32'd5);

    cur_req = "R2";
    for (int i = 0; i < 800; i++) begin
      int r = $urandom_range(9, 0);
      if (r < 2) cyc(3'($urandom_range(7, 0)), 1'b1, {$urandom_range(65535, 0), 8'h0, 1'b1, 7'($urandom_range(127, 0))}, bit'($urandom_range(1, 0)));
      else cyc(3'($urandom_range(7, 0)), 1'b0, 32'd0, bit'($urandom_range(1, 0)));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule